// File: doc/BRIEF.md
# Byte-Granular Store-to-Load Forwarding Unit

This block sits between a queue of older stores that have not yet drained to memory and the load path of a core. Each queued store carries an address, a power-of-two size and flags that say whether its address and its data are known yet. When a load arrives, the unit looks at every byte the load needs. Each byte is taken from the youngest queued store that covers it, as long as that store's data is known. The unit reports which bytes were forwarded and which queue slot supplied each one. Bytes that no store covers are left outstanding and are filled by one read from a memory port.

A load whose address is a multiple of its size is one operation of that size. A misaligned load is handled as a set of independent one-byte operations, so each byte may come from a different source. If a covering store still has its data pending, or if any queued store still has an unknown address, the load waits in the unit until the queue resolves. Atomic read-modify-write loads never take forwarded data. They are served wholly from memory.

The store queue is written by the surrounding pipeline. It can allocate an entry, fill in that entry's address and size, fill in its data, and drain the oldest entry. Memory is written by an agent outside the unit; the bench models this when it drains an entry. Sizes are encoded as log2 of the byte count: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes. Data is little-endian: byte lane i of a store or a load belongs to address + i.

Top module: `stfwd_unit`

## Requirements
- R1: After reset the queue is empty and `ld_busy`, `fwd_vld`, `mem_rd_en` and `ld_done` are all 0. A load issued then reads every needed byte from memory.
- R2: `ld_split` is 1 exactly when the load address is not a multiple of its byte count. Each byte of a misaligned load is resolved on its own.
- R3: For each needed byte lane, the source is the youngest valid queue entry that covers the byte address and has both its address and its data known. This holds even when the queue pointers wrap. `fwd_mask[i]` is set for that lane, and `fwd_src[3*i +: 3]` gives the slot number, for the default depth of 8.
- R4: Bytes that no store covers are marked in `miss_mask`. The masks are disjoint, and `fwd_mask | miss_mask` equals the lanes below the load's byte count.
- R5: A memory read is issued, with `mem_rd_mask` equal to `miss_mask`, if and only if `miss_mask` is nonzero. A read fills every outstanding byte from `mem_rd_data`. If every byte is forwarded, `ld_done` rises in the same cycle as `fwd_vld` and no read is issued.
- R6: If the youngest entry covering a needed byte has its data unknown, the load waits with no result until that data is written. A data-pending store that covers no needed byte does not delay the load.
- R7: While any valid queue entry has an unknown address, a non-atomic load waits with no result.
- R8: A drained entry is never a source. Bytes it wrote come back through the memory read.
- R9: A load with `ld_atomic` set neither waits on nor forwards from the queue. All of its needed bytes come from memory.
- R10: In `ld_data`, lanes at or above the load's byte count read 0. In `fwd_src`, lanes not forwarded read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sq_push | input | 1 | Allocate a queue entry at the tail (address and data unknown); ignored when full |
| sq_addr_wr | input | 1 | Write address and size of entry `sq_addr_idx` |
| sq_addr_idx | input | 3 | Entry index for the address write |
| sq_addr | input | 16 | Store byte address |
| sq_size | input | 2 | Store size, log2 of bytes |
| sq_data_wr | input | 1 | Write data of entry `sq_data_idx` |
| sq_data_idx | input | 3 | Entry index for the data write |
| sq_data | input | 64 | Store data, lane i for address + i |
| sq_pop | input | 1 | Drain the oldest entry; ignored when empty |
| ld_req | input | 1 | Start a load, accepted when not busy |
| ld_addr | input | 16 | Load byte address |
| ld_size | input | 2 | Load size, log2 of bytes |
| ld_atomic | input | 1 | Load belongs to an atomic read-modify-write |
| ld_busy | output | 1 | A load is in progress |
| fwd_vld | output | 1 | One-cycle pulse: forwarding result is valid |
| fwd_data | output | 64 | Forwarded bytes, 0 in lanes not forwarded |
| fwd_mask | output | 8 | Lanes satisfied by forwarding |
| miss_mask | output | 8 | Lanes still outstanding |
| fwd_src | output | 24 | Per-lane source slot, 3 bits per lane |
| ld_split | output | 1 | Load was misaligned and split into bytes |
| mem_rd_en | output | 1 | One-cycle memory read request |
| mem_rd_addr | output | 16 | Base byte address of the read |
| mem_rd_mask | output | 8 | Lanes the read must supply |
| mem_rd_vld | input | 1 | Read data valid |
| mem_rd_data | input | 64 | Read bytes, lane i from address + i |
| ld_done | output | 1 | One-cycle pulse: load value valid |
| ld_data | output | 64 | Assembled load value |

## Verification
A wrong age order or pointer state in the queue shows up at once as a wrong `fwd_src` slot or a byte taken from an older store. This is plainest when entries wrap and overlap the same address. Stale data-known or address-known flags show up in one of two ways. Either a load completes while it should still be waiting, seen by counting `fwd_vld` pulses during a held stall, or the load never completes. A wrong per-lane cover test shows up as a `fwd_mask`/`miss_mask` split that disagrees with a byte-level reference in the very load that touches the lane. A bad merge shows up as a wrong `ld_data` byte two cycles after the memory read.

// File: rtl/stfwd_pkg.sv
package stfwd_pkg;
  // Load controller phases
  typedef enum logic [1:0] {
    LD_IDLE = 2'd0,
    LD_LOOK = 2'd1,
    LD_MEMW = 2'd2
  } ld_state_e;
endpackage

// File: rtl/stfwd_queue.sv
// Circular queue of older stores. DEPTH must be a power of two.
module stfwd_queue #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DB    = 8,
  parameter int SZW   = 2,
  parameter int IW    = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 push,
  input  logic                 addr_wr,
  input  logic [IW-1:0]        addr_idx,
  input  logic [AW-1:0]        addr_in,
  input  logic [SZW-1:0]       size_in,
  input  logic                 data_wr,
  input  logic [IW-1:0]        data_idx,
  input  logic [DB*8-1:0]      data_in,
  input  logic                 pop,
  output logic [DEPTH-1:0]     e_vld,
  output logic [DEPTH-1:0]     e_ak,
  output logic [DEPTH-1:0]     e_dk,
  output logic [AW-1:0]        e_addr [DEPTH],
  output logic [SZW-1:0]       e_size [DEPTH],
  output logic [DB*8-1:0]      e_data [DEPTH],
  output logic [IW-1:0]        head
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [IW-1:0] head_q, tail_q;
  logic [CW-1:0] cnt_q;
  logic          full, do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push & ~full;
  assign do_pop  = pop & (cnt_q != '0);
  assign head    = head_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      e_vld  <= '0;
      e_ak   <= '0;
      e_dk   <= '0;
    end else begin
      if (do_push) begin
        e_vld[tail_q] <= 1'b1;
        e_ak[tail_q]  <= 1'b0;
        e_dk[tail_q]  <= 1'b0;
        tail_q        <= tail_q + 1'b1;
      end
      if (addr_wr) e_ak[addr_idx] <= 1'b1;
      if (data_wr) e_dk[data_idx] <= 1'b1;
      if (do_pop) begin
        e_vld[head_q] <= 1'b0;
        head_q        <= head_q + 1'b1;
      end
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // Payload fields carry no reset, as in a RAM-style array
  always_ff @(posedge clk) begin
    if (addr_wr) begin
      e_addr[addr_idx] <= addr_in;
      e_size[addr_idx] <= size_in;
    end
    if (data_wr) e_data[data_idx] <= data_in;
  end

  a_r1_count_bound : assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH));
  a_r8_drain_clears : assert property (@(posedge clk) disable iff (rst)
    do_pop |=> !e_vld[$past(head_q)]);
endmodule

// File: rtl/stfwd_match.sv
// Per-byte source selection: one lane block per load byte.
module stfwd_match #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DB    = 8,
  parameter int SZW   = 2,
  parameter int IW    = 3
) (
  input  logic [DEPTH-1:0]   e_vld,
  input  logic [DEPTH-1:0]   e_ak,
  input  logic [DEPTH-1:0]   e_dk,
  input  logic [AW-1:0]      e_addr [DEPTH],
  input  logic [SZW-1:0]     e_size [DEPTH],
  input  logic [DB*8-1:0]    e_data [DEPTH],
  input  logic [IW-1:0]      head,
  input  logic [AW-1:0]      ld_addr,
  input  logic [SZW-1:0]     ld_size,
  input  logic               ld_atomic,
  output logic [DB-1:0]      need_mask,
  output logic [DB-1:0]      hit_mask,
  output logic [DB-1:0]      blk_mask,
  output logic [DB*8-1:0]    fwd_data,
  output logic [DB*IW-1:0]   src_idx,
  output logic               unknown
);
  localparam int LB = (DB > 1) ? $clog2(DB) : 1;

  // Physical slot for each age position, oldest first
  logic [IW-1:0] ord [DEPTH];
  for (genvar k = 0; k < DEPTH; k++) begin : g_ord
    assign ord[k] = head + IW'(k);
  end

  assign unknown = (|(e_vld & ~e_ak)) & ~ld_atomic;

  for (genvar i = 0; i < DB; i++) begin : g_lane
    localparam int unsigned LANE = i;
    logic [AW-1:0]    lane_addr;
    logic [AW-1:0]    offs [DEPTH];
    logic [DEPTH-1:0] cov;
    logic             sel, sdk;
    logic [IW-1:0]    sidx;
    logic [7:0]       sbyte;

    assign lane_addr = ld_addr + AW'(i);

    for (genvar j = 0; j < DEPTH; j++) begin : g_ent
      assign offs[j] = lane_addr - e_addr[j];
      assign cov[j]  = e_vld[j] & e_ak[j] & (offs[j] < (AW'(1) << e_size[j]));
    end

    // Later (younger) hits override earlier ones
    always_comb begin
      sel   = 1'b0;
      sdk   = 1'b0;
      sidx  = '0;
      sbyte = '0;
      for (int k = 0; k < DEPTH; k++) begin
        if (cov[ord[k]]) begin
          sel   = 1'b1;
          sdk   = e_dk[ord[k]];
          sidx  = ord[k];
          sbyte = e_data[ord[k]][{offs[ord[k]][LB-1:0], 3'b000} +: 8];
        end
      end
    end

    assign need_mask[i] = (LANE < (32'd1 << ld_size));
    assign hit_mask[i]  = need_mask[i] & sel & sdk & ~ld_atomic;
    assign blk_mask[i]  = need_mask[i] & sel & ~sdk & ~ld_atomic;
    assign fwd_data[i*8 +: 8]   = hit_mask[i] ? sbyte : 8'h00;
    assign src_idx[i*IW +: IW]  = hit_mask[i] ? sidx : '0;
  end
endmodule

// File: rtl/stfwd_unit.sv
module stfwd_unit #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DB    = 8,
  localparam int IW   = $clog2(DEPTH),
  localparam int SZW  = $clog2($clog2(DB) + 1),
  localparam int DW   = DB * 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sq_push,
  input  logic             sq_addr_wr,
  input  logic [IW-1:0]    sq_addr_idx,
  input  logic [AW-1:0]    sq_addr,
  input  logic [SZW-1:0]   sq_size,
  input  logic             sq_data_wr,
  input  logic [IW-1:0]    sq_data_idx,
  input  logic [DW-1:0]    sq_data,
  input  logic             sq_pop,
  input  logic             ld_req,
  input  logic [AW-1:0]    ld_addr,
  input  logic [SZW-1:0]   ld_size,
  input  logic             ld_atomic,
  output logic             ld_busy,
  output logic             fwd_vld,
  output logic [DW-1:0]    fwd_data,
  output logic [DB-1:0]    fwd_mask,
  output logic [DB-1:0]    miss_mask,
  output logic [DB*IW-1:0] fwd_src,
  output logic             ld_split,
  output logic             mem_rd_en,
  output logic [AW-1:0]    mem_rd_addr,
  output logic [DB-1:0]    mem_rd_mask,
  input  logic             mem_rd_vld,
  input  logic [DW-1:0]    mem_rd_data,
  output logic             ld_done,
  output logic [DW-1:0]    ld_data
);
  import stfwd_pkg::*;

  logic [DEPTH-1:0] e_vld, e_ak, e_dk;
  logic [AW-1:0]    e_addr [DEPTH];
  logic [SZW-1:0]   e_size [DEPTH];
  logic [DW-1:0]    e_data [DEPTH];
  logic [IW-1:0]    head;

  stfwd_queue #(.DEPTH(DEPTH), .AW(AW), .DB(DB), .SZW(SZW), .IW(IW)) u_queue (
    .clk(clk), .rst(rst), .push(sq_push),
    .addr_wr(sq_addr_wr), .addr_idx(sq_addr_idx), .addr_in(sq_addr), .size_in(sq_size),
    .data_wr(sq_data_wr), .data_idx(sq_data_idx), .data_in(sq_data), .pop(sq_pop),
    .e_vld(e_vld), .e_ak(e_ak), .e_dk(e_dk), .e_addr(e_addr), .e_size(e_size),
    .e_data(e_data), .head(head)
  );

  ld_state_e      state_q;
  logic [AW-1:0]  ldq_addr;
  logic [SZW-1:0] ldq_size;
  logic           ldq_atomic;

  logic [DB-1:0]    m_need, m_hit, m_blk, m_miss;
  logic [DW-1:0]    m_fwd;
  logic [DB*IW-1:0] m_src;
  logic             m_unknown, stall, misal;

  stfwd_match #(.DEPTH(DEPTH), .AW(AW), .DB(DB), .SZW(SZW), .IW(IW)) u_match (
    .e_vld(e_vld), .e_ak(e_ak), .e_dk(e_dk), .e_addr(e_addr), .e_size(e_size),
    .e_data(e_data), .head(head),
    .ld_addr(ldq_addr), .ld_size(ldq_size), .ld_atomic(ldq_atomic),
    .need_mask(m_need), .hit_mask(m_hit), .blk_mask(m_blk),
    .fwd_data(m_fwd), .src_idx(m_src), .unknown(m_unknown)
  );

  assign m_miss  = m_need & ~m_hit;
  assign stall   = (|m_blk) | m_unknown;
  assign misal   = (ldq_addr & ((AW'(1) << ldq_size) - AW'(1))) != '0;
  assign ld_busy = (state_q != LD_IDLE);

  // Merge memory bytes into outstanding lanes
  logic [DW-1:0] merged;
  for (genvar i = 0; i < DB; i++) begin : g_merge
    assign merged[i*8 +: 8] = miss_mask[i] ? mem_rd_data[i*8 +: 8] : fwd_data[i*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= LD_IDLE;
      ldq_addr    <= '0;
      ldq_size    <= '0;
      ldq_atomic  <= 1'b0;
      fwd_vld     <= 1'b0;
      fwd_data    <= '0;
      fwd_mask    <= '0;
      miss_mask   <= '0;
      fwd_src     <= '0;
      ld_split    <= 1'b0;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
      mem_rd_mask <= '0;
      ld_done     <= 1'b0;
      ld_data     <= '0;
    end else begin
      fwd_vld   <= 1'b0;
      mem_rd_en <= 1'b0;
      ld_done   <= 1'b0;
      case (state_q)
        LD_IDLE: begin
          if (ld_req) begin
            ldq_addr   <= ld_addr;
            ldq_size   <= ld_size;
            ldq_atomic <= ld_atomic;
            state_q    <= LD_LOOK;
          end
        end
        LD_LOOK: begin
          if (!stall) begin
            fwd_vld   <= 1'b1;
            fwd_data  <= m_fwd;
            fwd_mask  <= m_hit;
            miss_mask <= m_miss;
            fwd_src   <= m_src;
            ld_split  <= misal;
            if (m_miss == '0) begin
              ld_done <= 1'b1;
              ld_data <= m_fwd;
              state_q <= LD_IDLE;
            end else begin
              mem_rd_en   <= 1'b1;
              mem_rd_addr <= ldq_addr;
              mem_rd_mask <= m_miss;
              state_q     <= LD_MEMW;
            end
          end
        end
        LD_MEMW: begin
          if (mem_rd_vld) begin
            ld_done <= 1'b1;
            ld_data <= merged;
            state_q <= LD_IDLE;
          end
        end
        default: state_q <= LD_IDLE;
      endcase
    end
  end

  a_r4_masks_disjoint : assert property (@(posedge clk) disable iff (rst)
    fwd_vld |-> ((fwd_mask & miss_mask) == '0));
  a_r5_read_iff_miss : assert property (@(posedge clk) disable iff (rst)
    fwd_vld |-> (mem_rd_en == (miss_mask != '0)));
  a_r5_done_when_covered : assert property (@(posedge clk) disable iff (rst)
    (fwd_vld && miss_mask == '0) |-> ld_done);
  a_r9_atomic_no_forward : assert property (@(posedge clk) disable iff (rst)
    (fwd_vld && ldq_atomic) |-> (fwd_mask == '0 && miss_mask != '0));
  a_r7_unknown_stalls : assert property (@(posedge clk) disable iff (rst)
    (state_q == LD_LOOK && m_unknown) |=> !fwd_vld);
  a_r6_pending_data_stalls : assert property (@(posedge clk) disable iff (rst)
    (state_q == LD_LOOK && m_blk != '0) |=> !fwd_vld);
endmodule

// File: tb/test_stfwd_unit.sv
module test_stfwd_unit;
  localparam int CLK_P = 10;

  logic        clk = 0, rst = 1;
  logic        sq_push = 0, sq_addr_wr = 0, sq_data_wr = 0, sq_pop = 0;
  logic [2:0]  sq_addr_idx = 0, sq_data_idx = 0;
  logic [15:0] sq_addr = 0;
  logic [1:0]  sq_size = 0;
  logic [63:0] sq_data = 0;
  logic        ld_req = 0, ld_atomic = 0;
  logic [15:0] ld_addr = 0;
  logic [1:0]  ld_size = 0;
  logic        ld_busy, fwd_vld, ld_split, mem_rd_en, ld_done;
  logic [63:0] fwd_data, ld_data;
  logic [7:0]  fwd_mask, miss_mask, mem_rd_mask;
  logic [23:0] fwd_src;
  logic [15:0] mem_rd_addr;
  logic        mem_rd_vld = 0;
  logic [63:0] mem_rd_data = 0;

  always #(CLK_P/2) clk = ~clk;

  stfwd_unit i_stfwd_unit (
    .clk(clk), .rst(rst), .sq_push(sq_push), .sq_addr_wr(sq_addr_wr),
    .sq_addr_idx(sq_addr_idx), .sq_addr(sq_addr), .sq_size(sq_size),
    .sq_data_wr(sq_data_wr), .sq_data_idx(sq_data_idx), .sq_data(sq_data),
    .sq_pop(sq_pop), .ld_req(ld_req), .ld_addr(ld_addr), .ld_size(ld_size),
    .ld_atomic(ld_atomic), .ld_busy(ld_busy), .fwd_vld(fwd_vld),
    .fwd_data(fwd_data), .fwd_mask(fwd_mask), .miss_mask(miss_mask),
    .fwd_src(fwd_src), .ld_split(ld_split), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_mask(mem_rd_mask),
    .mem_rd_vld(mem_rd_vld), .mem_rd_data(mem_rd_data),
    .ld_done(ld_done), .ld_data(ld_data)
  );

  int n_chk = 0, n_bad = 0, n_fwd = 0, n_rd = 0;

  // Reference state: memory bytes and queue model
  logic [7:0]  mem_b [256];
  logic        m_vld [8], m_ak [8], m_dk [8];
  int          m_addr [8], m_size [8];
  logic [63:0] m_data [8];
  int          m_head = 0, m_tail = 0;

  typedef struct {
    logic [63:0] data;
    logic [7:0]  fm, mm;
    logic [23:0] src;
    logic        sp;
  } exp_t;
  exp_t  sb [$];
  string sb_tag [$];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Memory responder: one-cycle latency, full line of bytes
  always @(posedge clk) begin
    mem_rd_vld <= 1'b0;
    if (!rst && mem_rd_en) begin
      mem_rd_vld <= 1'b1;
      for (int i = 0; i < 8; i++)
        mem_rd_data[i*8 +: 8] <= mem_b[8'(mem_rd_addr + 16'(i))];
      n_rd <= n_rd + 1;
    end
  end

  // Monitor: compare each finished load with the front of the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (fwd_vld) n_fwd++;
      if (ld_done) begin
        if (sb.size() == 0) begin
          chk("R5 unexpected ld_done", 64'd1, 64'd0);
        end else begin
          exp_t e;
          string t;
          e = sb.pop_front();
          t = sb_tag.pop_front();
          chk({t, " ld_data"}, ld_data, e.data);
          chk({t, " R3 fwd_mask"}, {56'd0, fwd_mask}, {56'd0, e.fm});
          chk({t, " R4 miss_mask"}, {56'd0, miss_mask}, {56'd0, e.mm});
          chk({t, " R10 fwd_src"}, {40'd0, fwd_src}, {40'd0, e.src});
          chk({t, " R2 ld_split"}, {63'd0, ld_split}, {63'd0, e.sp});
        end
      end
    end
  end

  function automatic exp_t ref_ld(input int a, input int sz, input bit at);
    exp_t e;
    int n, ba, hit, off;
    e.data = '0; e.fm = '0; e.mm = '0; e.src = '0;
    n = 1 << sz;
    e.sp = (a % n) != 0;
    for (int i = 0; i < n; i++) begin
      ba  = (a + i) & 16'hFFFF;
      hit = -1;
      for (int k = 0; k < 8; k++) begin
        int j;
        j = (m_head + k) % 8;
        if (m_vld[j] && m_ak[j] && ba >= m_addr[j] && ba < m_addr[j] + (1 << m_size[j]))
          hit = j;
      end
      if (!at && hit >= 0 && m_dk[hit]) begin
        off = ba - m_addr[hit];
        e.fm[i] = 1'b1;
        e.data[i*8 +: 8] = 8'(m_data[hit] >> (off*8));
        e.src[i*3 +: 3]  = 3'(hit);
      end else begin
        e.mm[i] = 1'b1;
        e.data[i*8 +: 8] = mem_b[ba & 255];
      end
    end
    return e;
  endfunction

  task automatic sq_push_t();
    m_vld[m_tail] = 1; m_ak[m_tail] = 0; m_dk[m_tail] = 0;
    m_tail = (m_tail + 1) % 8;
    @(negedge clk); sq_push = 1;
    @(negedge clk); sq_push = 0;
  endtask

  task automatic sq_addr_t(input int idx, input int a, input int sz);
    m_ak[idx] = 1; m_addr[idx] = a; m_size[idx] = sz;
    @(negedge clk); sq_addr_wr = 1; sq_addr_idx = 3'(idx); sq_addr = 16'(a); sq_size = 2'(sz);
    @(negedge clk); sq_addr_wr = 0;
  endtask

  task automatic sq_data_t(input int idx, input logic [63:0] d);
    m_dk[idx] = 1; m_data[idx] = d;
    @(negedge clk); sq_data_wr = 1; sq_data_idx = 3'(idx); sq_data = d;
    @(negedge clk); sq_data_wr = 0;
  endtask

  task automatic sq_pop_t();
    for (int i = 0; i < (1 << m_size[m_head]); i++)
      mem_b[(m_addr[m_head] + i) & 255] = 8'(m_data[m_head] >> (i*8));
    m_vld[m_head] = 0;
    m_head = (m_head + 1) % 8;
    @(negedge clk); sq_pop = 1;
    @(negedge clk); sq_pop = 0;
  endtask

  task automatic ld_expect(input int a, input int sz, input bit at, input string tag);
    sb.push_back(ref_ld(a, sz, at));
    sb_tag.push_back(tag);
  endtask

  task automatic ld_send(input int a, input int sz, input bit at);
    @(negedge clk); ld_req = 1; ld_addr = 16'(a); ld_size = 2'(sz); ld_atomic = at;
    @(negedge clk); ld_req = 0;
  endtask

  task automatic ld_wait();
    while (ld_busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic ld_full(input int a, input int sz, input bit at, input string tag);
    ld_expect(a, sz, at, tag);
    ld_send(a, sz, at);
    ld_wait();
  endtask

  bit finished = 0;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int rd0, f0;
    for (int k = 0; k < 256; k++) mem_b[k] = 8'(k) ^ 8'h5A;
    for (int k = 0; k < 8; k++) begin
      m_vld[k] = 0; m_ak[k] = 0; m_dk[k] = 0; m_addr[k] = 0; m_size[k] = 0; m_data[k] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state of the load path
    chk("R1 ld_busy", {63'd0, ld_busy}, 64'd0);
    chk("R1 fwd_vld", {63'd0, fwd_vld}, 64'd0);
    chk("R1 mem_rd_en", {63'd0, mem_rd_en}, 64'd0);
    chk("R1 ld_done", {63'd0, ld_done}, 64'd0);

    rd0 = n_rd;
    ld_full(16'h10, 3, 0, "R1 empty queue");
    chk("R5 read issued for misses", 64'(n_rd - rd0), 64'd1);

    // Store slot 0: 4 bytes at 0x10
    sq_push_t(); sq_addr_t(0, 16'h10, 2); sq_data_t(0, 64'h44332211);
    ld_full(16'h10, 3, 0, "R4 partial forward");

    // Store slot 1: 2 bytes at 0x12, younger overlap
    sq_push_t(); sq_addr_t(1, 16'h12, 1); sq_data_t(1, 64'hBBAA);
    rd0 = n_rd;
    ld_full(16'h12, 1, 0, "R5 fully forwarded");
    chk("R5 no read when covered", 64'(n_rd - rd0), 64'd0);
    ld_full(16'h13, 2, 0, "R2 misaligned load");
    ld_full(16'h11, 1, 0, "R3 youngest per byte");

    // Slot 2: address known, data pending, 8 bytes at 0x40
    sq_push_t(); sq_addr_t(2, 16'h40, 3);
    ld_full(16'h20, 2, 0, "R6 non-overlapping pending store");
    f0 = n_fwd;
    ld_send(16'h44, 0, 0);
    repeat (6) @(negedge clk);
    chk("R6 waits on pending data busy", {63'd0, ld_busy}, 64'd1);
    chk("R6 no result while pending", 64'(n_fwd - f0), 64'd0);
    sq_data_t(2, 64'h0807060504030201);
    ld_expect(16'h44, 0, 0, "R6 after data");
    ld_wait();

    // Slot 3: address unknown
    sq_push_t();
    f0 = n_fwd;
    ld_send(16'h20, 1, 0);
    repeat (6) @(negedge clk);
    chk("R7 waits on unknown address busy", {63'd0, ld_busy}, 64'd1);
    chk("R7 no result while unknown", 64'(n_fwd - f0), 64'd0);
    sq_addr_t(3, 16'h80, 0);
    ld_expect(16'h20, 1, 0, "R7 after address");
    ld_wait();
    sq_data_t(3, 64'hEE);

    // Atomic loads: covered bytes still come from memory; unknown address ignored
    ld_full(16'h10, 3, 1, "R9 atomic covered");
    sq_push_t();
    ld_full(16'h40, 3, 1, "R9 atomic with unknown address");

    // Slot 4: misaligned 4-byte store at 0x31
    sq_addr_t(4, 16'h31, 2); sq_data_t(4, 64'hD4C3B2A1);
    ld_full(16'h30, 3, 0, "R3 misaligned store");

    // Drain slot 0; its bytes must come from memory
    sq_pop_t();
    ld_full(16'h10, 2, 0, "R8 drained store");

    // Empty the queue, then wrap: slots 5,6,7,0
    repeat (4) sq_pop_t();
    sq_push_t(); sq_addr_t(5, 16'h61, 0); sq_data_t(5, 64'h51);
    sq_push_t(); sq_addr_t(6, 16'h62, 0); sq_data_t(6, 64'h62);
    sq_push_t(); sq_addr_t(7, 16'h60, 0); sq_data_t(7, 64'h70);
    sq_push_t(); sq_addr_t(0, 16'h60, 1); sq_data_t(0, 64'h0908);
    ld_full(16'h60, 2, 0, "R3 wrapped order");
    ld_full(16'h5F, 0, 0, "R10 one-byte miss");

    repeat (3) @(negedge clk);
    chk("R5 all loads completed", 64'(sb.size()), 64'd0);
    finished = 1;
    summary();
    $finish;
  end
endmodule